// File: doc/BRIEF.md
# Watchdog Timer with Partial-Width Match and Three-Strike Reset

This block is a watchdog for a system that runs from a slow 32768 Hz time base. A one-cycle `tick` pulse, already brought into the `clk` domain, advances a free-running 16-bit counter. On every enabled tick the counter is compared with a programmed match value. A programmable number of the counter's top bits can be left out of that comparison. Each bit left out halves the repeat period of match events, so one match register covers timeouts from a few milliseconds up to several seconds.

Match events that software has not serviced walk through three strikes. The first strike raises a pending flag, which drives a maskable interrupt. The second strike is recorded. The third strike latches a reset request that only the block's own reset clears. From a kick to the reset request, an unserviced run therefore lasts two full periods of the compared field plus the match offset. A kick clears the strikes and the pending flag, and it is accepted even while the block is locked. Software reads the counter and can reprogram the match value at kick time as the current count plus an offset. Writes to the enable, ignore-count and match fields are accepted only after a two-step key sequence.

Top module: `wdt_ignore_match`

## Requirements
- R1: After reset the counter reads 0, the block is disabled with ignore count 0 and match 0, the status reads 0x10 (locked, no strikes), and `irq` and `reset_req` are low.
- R2: While enabled, the counter increases by one on each `tick` cycle. While disabled, it holds its value.
- R3: With ignore count N, a match event occurs on an enabled tick when the low 16−N bits of the counter value before the increment equal the low 16−N bits of the match register. The upper match bits have no effect. The ignore count is written to CTRL bits [4:1], and any value above 12 is stored as 12.
- R4: The first match event after a kick sets pending (STATUS bit 0), and strikes are counted in STATUS bits [2:1]. `irq` is pending AND NOT mask. With the mask set, match events still advance the strikes.
- R5: The third unserviced match event sets the fire flag (STATUS bit 3). A kick does not clear it, and only `rst_n` does. `reset_req` equals fire AND enable, so disabling the block drops it.
- R6: Any write to KICK (address 3) clears pending and the strike count, and it works while the block is locked. When a kick and a match event fall in the same cycle, the kick wins and no strike is added.
- R7: CTRL (address 0: bit 0 enable, bits [4:1] ignore count) and MATCH (address 1) change only while the block is unlocked. Writes made while locked are dropped. A write of 01 to LOCK (address 2, bits [1:0]), followed by a LOCK write of 10 as the next LOCK write, unlocks the block. Any other LOCK value locks it. Lock state is STATUS bit 4.
- R8: The counter reads at address 5. A new match value is used from the first tick after the write.
- R9: The mask (address 4, bit 0) can be written whether the block is locked or not, and it reads back at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per low-speed time-base period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 CTRL, 1 MATCH, 2 LOCK, 3 KICK, 4 MASK) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address (0 CTRL, 1 MATCH, 4 MASK, 5 COUNT, 6 STATUS) |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Maskable watchdog interrupt |
| reset_req | output | 1 | System reset request |

## Verification
A kick and a match event can fall in the same clock cycle. Resolving that collision correctly decides whether a late service still saves the system. The bench first brings the block to two strikes. It then runs the counter to one tick before the third match value and drives a KICK write and the matching tick in the same cycle. The strikes, pending and the fire flag must all read cleared, and `reset_req` must stay low. A separate run lets the third match go unserviced and confirms that a later kick leaves the reset request in place.

// File: rtl/wdt_ign_pkg.sv
package wdt_ign_pkg;
   typedef enum logic [2:0] {
      ADR_CTRL   = 3'd0,
      ADR_MATCH  = 3'd1,
      ADR_LOCK   = 3'd2,
      ADR_KICK   = 3'd3,
      ADR_MASK   = 3'd4,
      ADR_COUNT  = 3'd5,
      ADR_STATUS = 3'd6
   } wdt_adr_e;
endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
   parameter int               KEY_W = 2,
   parameter logic [KEY_W-1:0] KEY_A = 2'b01,
   parameter logic [KEY_W-1:0] KEY_B = 2'b10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_we,
   input  logic [KEY_W-1:0] key,
   output logic             locked
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b1;
         armed  <= 1'b0;
      end else if (key_we) begin
         if (key == KEY_A) begin
            locked <= 1'b1;
            armed  <= 1'b1;
         end else if (key == KEY_B && armed) begin
            locked <= 1'b0;
            armed  <= 1'b0;
         end else begin
            locked <= 1'b1;
            armed  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs #(
   parameter int CNT_W   = 16,
   parameter int IGN_W   = 4,
   parameter int IGN_MAX = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             wr_ctrl,
   input  logic             wr_match,
   input  logic             wr_mask,
   input  logic [CNT_W-1:0] wr_data,
   output logic             en_q,
   output logic [IGN_W-1:0] ign_q,
   output logic [CNT_W-1:0] match_q,
   output logic             mask_q
);
   localparam logic [IGN_W-1:0] IGN_CAP = IGN_W'(IGN_MAX);

   logic [IGN_W-1:0] ign_raw;
   logic [IGN_W-1:0] ign_new;

   always_comb begin
      ign_raw = wr_data[IGN_W:1];
      ign_new = (ign_raw > IGN_CAP) ? IGN_CAP : ign_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         ign_q   <= '0;
         match_q <= '0;
         mask_q  <= 1'b0;
      end else begin
         if (wr_ctrl && !locked) begin
            en_q  <= wr_data[0];
            ign_q <= ign_new;
         end
         if (wr_match && !locked) begin
            match_q <= wr_data;
         end
         if (wr_mask) begin
            mask_q <= wr_data[0];
         end
      end
   end
endmodule

// File: rtl/wdt_match_cmp.sv
module wdt_match_cmp #(
   parameter int CNT_W   = 16,
   parameter int IGN_W   = 4,
   parameter int IGN_MAX = 12
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] match,
   input  logic [IGN_W-1:0] ign,
   output logic             hit
);
   localparam int CW = $clog2(CNT_W + 1);

   generate
      if (IGN_MAX == 0) begin : g_full
         assign hit = (cnt == match);
      end else begin : g_masked
         logic [CW-1:0]    ign_ext;
         logic [CNT_W-1:0] keep;
         logic [CNT_W-1:0] bit_ok;
         assign ign_ext = CW'(ign);
         for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            if (i < CNT_W - IGN_MAX) begin : g_always
               assign keep[i] = 1'b1;
            end else begin : g_opt
               assign keep[i] = (ign_ext <= CW'(CNT_W - 1 - i));
            end
            assign bit_ok[i] = ~keep[i] | (cnt[i] ~^ match[i]);
         end
         assign hit = &bit_ok;
      end
   endgenerate
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
   parameter int STAGES = 3,
   parameter int STG_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_ev,
   input  logic             kick,
   output logic [STG_W-1:0] stage,
   output logic             pending,
   output logic             fire
);
   localparam logic [STG_W-1:0] LAST = STG_W'(STAGES - 1);
   localparam logic [STG_W-1:0] FULL = STG_W'(STAGES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage   <= '0;
         pending <= 1'b0;
         fire    <= 1'b0;
      end else if (kick) begin
         stage   <= '0;
         pending <= 1'b0;
      end else if (hit_ev) begin
         pending <= 1'b1;
         if (stage != FULL) stage <= stage + STG_W'(1);
         if (stage == LAST) fire <= 1'b1;
      end
   end
endmodule

// File: rtl/wdt_ignore_match.sv
module wdt_ignore_match
   import wdt_ign_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter int               IGN_MAX = 12,
   parameter int               STAGES  = 3,
   parameter int               KEY_W   = 2,
   parameter logic [KEY_W-1:0] KEY_A   = 2'b01,
   parameter logic [KEY_W-1:0] KEY_B   = 2'b10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq,
   output logic             reset_req
);
   localparam int IGN_W = $clog2(IGN_MAX + 1);
   localparam int STG_W = $clog2(STAGES + 1);

   generate
      if (IGN_MAX >= CNT_W) begin : g_bad_ign
         $error("IGN_MAX must stay below CNT_W");
      end
      if (STAGES < 1) begin : g_bad_stg
         $error("STAGES must be at least one");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("unlock keys must differ");
      end
      if (CNT_W < STG_W + 3 || CNT_W < IGN_W + 1 || CNT_W < KEY_W) begin : g_bad_w
         $error("CNT_W too narrow for the register fields");
      end
   endgenerate

   logic             wr_ctrl, wr_match, wr_lock, wr_mask, kick_wr;
   logic             locked, en_q, mask_q;
   logic [IGN_W-1:0] ign_q;
   logic [CNT_W-1:0] match_q, cnt_q;
   logic             hit, hit_ev;
   logic [STG_W-1:0] stage;
   logic             pending, fire;

   always_comb begin
      wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
      wr_match = wr_en && (wr_addr == ADR_MATCH);
      wr_lock  = wr_en && (wr_addr == ADR_LOCK);
      kick_wr  = wr_en && (wr_addr == ADR_KICK);
      wr_mask  = wr_en && (wr_addr == ADR_MASK);
   end

   wdt_keylock #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_we (wr_lock),
      .key    (wr_data[KEY_W-1:0]),
      .locked (locked)
   );

   wdt_cfg_regs #(.CNT_W(CNT_W), .IGN_W(IGN_W), .IGN_MAX(IGN_MAX)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked),
      .wr_ctrl  (wr_ctrl),
      .wr_match (wr_match),
      .wr_mask  (wr_mask),
      .wr_data  (wr_data),
      .en_q     (en_q),
      .ign_q    (ign_q),
      .match_q  (match_q),
      .mask_q   (mask_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (en_q && tick) cnt_q <= cnt_q + CNT_W'(1);
   end

   wdt_match_cmp #(.CNT_W(CNT_W), .IGN_W(IGN_W), .IGN_MAX(IGN_MAX)) u_cmp (
      .cnt   (cnt_q),
      .match (match_q),
      .ign   (ign_q),
      .hit   (hit)
   );

   assign hit_ev = en_q && tick && hit;

   wdt_escalate #(.STAGES(STAGES), .STG_W(STG_W)) u_esc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_ev  (hit_ev),
      .kick    (kick_wr),
      .stage   (stage),
      .pending (pending),
      .fire    (fire)
   );

   assign irq       = pending && !mask_q;
   assign reset_req = fire && en_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_CTRL:   rd_data[IGN_W:0] = {ign_q, en_q};
         ADR_MATCH:  rd_data = match_q;
         ADR_MASK:   rd_data[0] = mask_q;
         ADR_COUNT:  rd_data = cnt_q;
         ADR_STATUS: rd_data[STG_W+2:0] = {locked, fire, stage, pending};
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/wdt_ign_chk.sv
module wdt_ign_chk #(
   parameter int CNT_W  = 16,
   parameter int STAGES = 3,
   parameter int STG_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick,
   input logic             irq,
   input logic             en_q,
   input logic [CNT_W-1:0] cnt,
   input logic             wr_match,
   input logic             locked,
   input logic [CNT_W-1:0] match_q,
   input logic [STG_W-1:0] stage,
   input logic             hit_ev,
   input logic             fire
);
   localparam logic [STG_W-1:0] LAST = STG_W'(STAGES - 1);

   p_kick_clears_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !irq);

   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(cnt));

   p_locked_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_match && locked) |=> $stable(match_q));

   p_third_strike_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ev && !kick && stage == LAST) |=> fire);

   p_fire_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> fire);

   p_strikes_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !kick |=> (stage >= $past(stage)));
endmodule

bind wdt_ignore_match wdt_ign_chk #(.CNT_W(CNT_W), .STAGES(STAGES), .STG_W(STG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .kick     (kick_wr),
   .irq      (irq),
   .en_q     (en_q),
   .cnt      (cnt_q),
   .wr_match (wr_match),
   .locked   (locked),
   .match_q  (match_q),
   .stage    (stage),
   .hit_ev   (hit_ev),
   .fire     (fire)
);

// File: tb/test_wdt_ignore_match.sv
module test_wdt_ignore_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq, reset_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [2:0] A_CTRL = 3'd0, A_MATCH = 3'd1, A_LOCK = 3'd2, A_KICK = 3'd3,
                          A_MASK = 3'd4, A_COUNT = 3'd5, A_STATUS = 3'd6;

   always #4 clk = ~clk;

   wdt_ignore_match i_wdt_ignore_match (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
      .reset_req(reset_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic rdchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
      rd_addr = a;
      #1;
      chk(tag, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic unlock();
      wr(A_LOCK, 16'h1);
      wr(A_LOCK, 16'h2);
   endtask

   task automatic t_reset();
      apply_reset();
      rdchk("R1 ctrl", A_CTRL, 16'h0);
      rdchk("R1 count", A_COUNT, 16'h0);
      rdchk("R1 match", A_MATCH, 16'h0);
      rdchk("R1 status", A_STATUS, 16'h10);
      chk("R1 irq", irq, 0);
      chk("R1 reset_req", reset_req, 0);
   endtask

   task automatic t_lock();
      apply_reset();
      wr(A_CTRL, 16'h1);
      rdchk("R7 locked ctrl write dropped", A_CTRL, 16'h0);
      unlock();
      rdchk("R7 unlocked status", A_STATUS, 16'h00);
      wr(A_MATCH, 16'h5);
      rdchk("R7 unlocked match write", A_MATCH, 16'h5);
      wr(A_LOCK, 16'h0);
      wr(A_MATCH, 16'h7);
      rdchk("R7 relocked match write dropped", A_MATCH, 16'h5);
      wr(A_LOCK, 16'h1);
      wr(A_LOCK, 16'h3);
      wr(A_LOCK, 16'h2);
      wr(A_MATCH, 16'h9);
      rdchk("R7 broken key sequence keeps lock", A_MATCH, 16'h5);
      rdchk("R7 lock bit", A_STATUS, 16'h10);
   endtask

   task automatic t_count();
      apply_reset();
      unlock();
      wr(A_CTRL, 16'd25);
      tick_n(3);
      rdchk("R2 counts ticks", A_COUNT, 16'd3);
      wr(A_CTRL, 16'd24);
      tick_n(2);
      rdchk("R2 holds when disabled", A_COUNT, 16'd3);
      wr(A_CTRL, 16'd30);
      rdchk("R3 ignore count clamps to 12", A_CTRL, 16'd24);
   endtask

   task automatic t_escalate();
      apply_reset();
      unlock();
      wr(A_MATCH, 16'h0F05);
      wr(A_CTRL, 16'd25);
      tick_n(5);
      rdchk("R3 no event before match", A_STATUS, 16'h0);
      tick_n(1);
      rdchk("R3 event on low bits, upper ignored", A_STATUS, 16'h3);
      chk("R4 irq on first strike", irq, 1);
      tick_n(16);
      rdchk("R3 second strike after one period", A_STATUS, 16'h5);
      chk("R5 no reset at second strike", reset_req, 0);
      tick_n(15);
      chk("R5 no reset before third strike", reset_req, 0);
      tick_n(1);
      chk("R5 reset on third strike", reset_req, 1);
      rdchk("R5 fire status", A_STATUS, 16'hF);
      rdchk("R2 count at fire", A_COUNT, 16'd38);
      wr(A_KICK, 16'h0);
      rdchk("R5 kick leaves fire", A_STATUS, 16'h8);
      chk("R5 reset_req sticky over kick", reset_req, 1);
      wr(A_CTRL, 16'd24);
      chk("R5 disable suppresses reset_req", reset_req, 0);
   endtask

   task automatic t_full_compare();
      apply_reset();
      unlock();
      wr(A_MATCH, 16'h0013);
      wr(A_CTRL, 16'h1);
      tick_n(19);
      rdchk("R3 full width no early event", A_STATUS, 16'h0);
      tick_n(1);
      rdchk("R3 full width event", A_STATUS, 16'h3);
   endtask

   task automatic t_mask();
      apply_reset();
      wr(A_MASK, 16'h1);
      rdchk("R9 mask written while locked", A_MASK, 16'h1);
      unlock();
      wr(A_CTRL, 16'd25);
      tick_n(1);
      rdchk("R4 masked strike still pending", A_STATUS, 16'h3);
      chk("R4 masked irq low", irq, 0);
      wr(A_MASK, 16'h0);
      chk("R4 unmask shows irq", irq, 1);
      wr(A_MASK, 16'h1);
      tick_n(16);
      rdchk("R4 masked strikes advance", A_STATUS, 16'h5);
      chk("R4 irq stays masked", irq, 0);
   endtask

   task automatic t_kick();
      apply_reset();
      unlock();
      wr(A_MATCH, 16'h2);
      wr(A_CTRL, 16'd25);
      wr(A_LOCK, 16'h0);
      tick_n(3);
      rdchk("R6 strike before kick", A_STATUS, 16'h13);
      wr(A_KICK, 16'h0);
      rdchk("R6 kick while locked clears", A_STATUS, 16'h10);
      chk("R6 irq cleared", irq, 0);
      tick_n(32);
      rdchk("R6 two strikes rebuilt", A_STATUS, 16'h15);
      tick_n(15);
      rdchk("R6 count before collision", A_COUNT, 16'd50);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = A_KICK; wr_data = 16'h0;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rdchk("R6 kick beats same-cycle match", A_STATUS, 16'h10);
      chk("R6 no reset after collision", reset_req, 0);
      chk("R6 irq low after collision", irq, 0);
   endtask

   task automatic t_match_update();
      apply_reset();
      unlock();
      wr(A_MATCH, 16'hF);
      wr(A_CTRL, 16'd25);
      tick_n(3);
      rdchk("R8 counter readable", A_COUNT, 16'd3);
      wr(A_MATCH, 16'd5);
      rdchk("R8 match readback", A_MATCH, 16'd5);
      tick_n(2);
      rdchk("R8 no event before new match", A_STATUS, 16'h0);
      tick_n(1);
      rdchk("R8 new match used", A_STATUS, 16'h3);
   endtask

   initial begin : watchdog
      #1200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired act=0 exp=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_lock();
      t_count();
      t_escalate();
      t_full_compare();
      t_mask();
      t_kick();
      t_match_update();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule